// File: doc/BRIEF.md
# Capture Clock Phase Sweep Engine

This block calibrates the phase of the clock that resamples the outputs of the strobe-clocked read capture registers. On request it steps a phase select through two full clock cycles, one step at a time. At each step it asks the clock generator to apply the new phase, waits for an acknowledge, and then takes a single pass/fail bit from the read-data comparator. The actual phase shifting and data comparison are outside the block. The bit is simply a function of the current phase.

Over the double sweep the engine tracks the longest run of consecutive passing steps. Two turns are swept so that a valid window which wraps across the cycle boundary is still seen as one run. The engine then reports the phase at the centre of that run, which gives the most margin on both sides, together with the run length. If no step passes, a fail flag is raised. The reported phase is later handed to background voltage and temperature tracking, which holds it in place.

The controller has five named states:
- SW_IDLE goes to SW_STEP when start is seen.
- SW_STEP goes to SW_SETTLE when the acknowledge arrives.
- SW_SETTLE goes to SW_STEP on the next step, or to SW_CENTRE after the last step, once the acknowledge has fallen.
- SW_CENTRE goes to SW_DONE unconditionally.
- SW_DONE goes to SW_IDLE unconditionally.

Top module: `phase_sweep_top`

## Requirements
- R1: After reset, step_req, done, no_window, busy, phase_sel, best_phase and win_width are all zero.
- R2: A sweep_start pulse while busy is low starts a sweep. On the next cycle busy and step_req are high and phase_sel is 0.
- R3: While step_req is high and step_ack is low, step_req stays high and phase_sel does not change.
- R4: cmp_pass is sampled only in a cycle where step_req and step_ack are both high. step_req is low on the next cycle, and the next request waits until step_ack is low. Each new request advances phase_sel by one, modulo STEPS.
- R5: One sweep makes exactly 2*STEPS handshakes. The phases run 0 to STEPS-1 twice.
- R6: win_width is the longest run of consecutive passing handshakes in the sweep, capped at STEPS.
- R7: best_phase is (S + win_width/2) mod STEPS, using integer division. S is the phase of the first step of the earliest run of maximal length.
- R8: A passing window that spans phase STEPS-1 to phase 0 is measured as a single run.
- R9: If no handshake passes, no_window is 1 and both best_phase and win_width are 0. Otherwise no_window is 0.
- R10: done is high for exactly one cycle, two cycles after the acknowledge of the last step falls. Results stay unchanged until the next sweep ends. sweep_start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_start | input | 1 | Start a calibration sweep |
| phase_sel | output | PW | Requested phase step |
| step_req | output | 1 | Phase change request |
| step_ack | input | 1 | Phase applied and compare result valid |
| cmp_pass | input | 1 | Compare result for the current phase |
| busy | output | 1 | Sweep in progress (any state other than SW_IDLE) |
| done | output | 1 | One-cycle sweep completion pulse |
| best_phase | output | PW | Centre of the widest passing window |
| win_width | output | WW | Width of that window in steps |
| no_window | output | 1 | No phase passed |

## Verification
On every cycle, the assertions check the handshake rules: the request is held with a stable phase until acknowledged, and it drops after the acknowledge. They also check that the start pulse launches a request at phase 0, that done lasts one cycle, and that the result registers stay in range and are zeroed on failure. Only the bench scenarios can show the window arithmetic. These cover a plain window, a wrapping window, tied windows, an all-pass mask, a single passing step and an all-fail mask. The bench also counts 2*STEPS handshakes under several acknowledge latencies and shows that a start pulse mid-sweep is ignored.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;
    typedef enum logic [2:0] {
        SW_IDLE,
        SW_STEP,
        SW_SETTLE,
        SW_CENTRE,
        SW_DONE
    } sweep_state_t;
endpackage

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
    import phase_sweep_pkg::*;
#(
    parameter int STEPS = 16,
    parameter int PW    = $clog2(STEPS),
    parameter int IW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ack,
    output logic [PW-1:0] phase_sel,
    output logic          req,
    output logic          busy,
    output logic          done,
    output logic          sample_en,
    output logic          clear,
    output logic          finalize
);
    localparam logic [IW-1:0] LAST  = IW'(2 * STEPS - 1);
    localparam logic [IW-1:0] TURN  = IW'(STEPS);

    sweep_state_t state, nxt;
    logic [IW-1:0] idx;
    logic [IW-1:0] wrapped;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SW_IDLE:   if (start) nxt = SW_STEP;
            SW_STEP:   if (ack)   nxt = SW_SETTLE;
            SW_SETTLE: if (!ack)  nxt = (idx == LAST) ? SW_CENTRE : SW_STEP;
            SW_CENTRE: nxt = SW_DONE;
            SW_DONE:   nxt = SW_IDLE;
            default:   nxt = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                            idx <= '0;
        else if (state == SW_IDLE && start)                    idx <= '0;
        else if (state == SW_SETTLE && !ack && idx != LAST)    idx <= idx + 1'b1;
    end

    // outputs
    always_comb begin
        wrapped   = (idx >= TURN) ? idx - TURN : idx;
        phase_sel = wrapped[PW-1:0];
        req       = (state == SW_STEP);
        busy      = (state != SW_IDLE);
        done      = (state == SW_DONE);
        sample_en = (state == SW_STEP) && ack;
        clear     = (state == SW_IDLE) && start;
        finalize  = (state == SW_CENTRE);
    end

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req);
    a_r3_phase_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> $stable(phase_sel));
    a_r4_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack |=> !req);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/phase_window_track.sv
module phase_window_track #(
    parameter int STEPS = 16,
    parameter int PW    = $clog2(STEPS),
    parameter int WW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample_en,
    input  logic          pass,
    input  logic [PW-1:0] step_phase,
    input  logic          finalize,
    output logic [PW-1:0] res_phase,
    output logic [WW-1:0] res_width,
    output logic          res_fail
);
    localparam logic [WW-1:0] CAP = WW'(STEPS);
    localparam int SW = PW + 1;

    logic [WW-1:0] run_len, best_len, grown;
    logic [PW-1:0] run_start, best_start, cand_start;
    logic [SW-1:0] centre_sum, centre;

    always_comb begin
        grown      = (run_len == CAP) ? CAP : run_len + 1'b1;
        cand_start = (run_len == '0) ? step_phase : run_start;
        centre_sum = SW'(best_start) + SW'(best_len >> 1);
        centre     = (centre_sum >= SW'(STEPS)) ? centre_sum - SW'(STEPS) : centre_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_len    <= '0;
            run_start  <= '0;
            best_len   <= '0;
            best_start <= '0;
        end else if (sample_en) begin
            if (pass) begin
                run_len   <= grown;
                run_start <= cand_start;
                if (grown > best_len) begin
                    best_len   <= grown;
                    best_start <= cand_start;
                end
            end else begin
                run_len <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_phase <= '0;
            res_width <= '0;
            res_fail  <= 1'b0;
        end else if (finalize) begin
            res_fail  <= (best_len == '0);
            res_width <= best_len;
            res_phase <= (best_len == '0) ? '0 : centre[PW-1:0];
        end
    end

    a_r6_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        res_width <= CAP);
    a_r9_fail_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        res_fail |-> (res_phase == '0 && res_width == '0));
    a_r7_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(res_phase) < SW'(STEPS));
endmodule

// File: rtl/phase_sweep_top.sv
module phase_sweep_top #(
    parameter int STEPS = 16,
    parameter int PW    = $clog2(STEPS),
    parameter int WW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    output logic [PW-1:0] phase_sel,
    output logic          step_req,
    input  logic          step_ack,
    input  logic          cmp_pass,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] best_phase,
    output logic [WW-1:0] win_width,
    output logic          no_window
);
    logic sample_en, clear, finalize;

    phase_sweep_ctrl #(.STEPS(STEPS), .PW(PW), .IW(PW + 1)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(sweep_start), .ack(step_ack),
        .phase_sel(phase_sel), .req(step_req), .busy(busy), .done(done),
        .sample_en(sample_en), .clear(clear), .finalize(finalize)
    );

    phase_window_track #(.STEPS(STEPS), .PW(PW), .WW(WW)) track_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample_en(sample_en),
        .pass(cmp_pass), .step_phase(phase_sel), .finalize(finalize),
        .res_phase(best_phase), .res_width(win_width), .res_fail(no_window)
    );

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && sweep_start |=> step_req && busy && phase_sel == '0);
    a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(finalize) |-> $stable(best_phase) && $stable(win_width));
endmodule

// File: tb/phase_sweep_top_tb_top.sv
module phase_sweep_top_tb_top;
    localparam int N  = 16;
    localparam int PW = $clog2(N);
    localparam int WW = $clog2(N + 1);

    logic clk = 0, rst_n = 0, sweep_start = 0, step_ack = 0, cmp_pass = 0;
    logic [PW-1:0] phase_sel, best_phase;
    logic [WW-1:0] win_width;
    logic step_req, busy, done, no_window;

    int checks = 0, errors = 0, cycles = 0;
    int hs_count = 0, wait_cnt = 0, lat = 0;
    bit monitor_on = 0;
    logic [N-1:0] mask = '0;

    phase_sweep_top #(.STEPS(N)) dut_i (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // responder and per-clock model comparison
    always @(negedge clk) begin
        cycles++;
        if (monitor_on && step_req && !step_ack)
            check("R4 phase order", int'(phase_sel), hs_count % N);
        if (step_req && !step_ack) begin
            if (wait_cnt >= lat) begin
                step_ack = 1;
                cmp_pass = mask[phase_sel];
                hs_count++;
                wait_cnt = 0;
            end else wait_cnt++;
        end else if (!step_req && step_ack) begin
            step_ack = 0;
            cmp_pass = 0;
        end
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic expect_result(input logic [N-1:0] m, output int w, output int ph, output int f);
        int run = 0, rs = 0, best = 0, bs = 0;
        for (int s = 0; s < 2 * N; s++) begin
            if (m[s % N]) begin
                if (run == 0) rs = s % N;
                if (run < N) run++;
                if (run > best) begin best = run; bs = rs; end
            end else run = 0;
        end
        w  = best;
        f  = (best == 0);
        ph = (best == 0) ? 0 : (bs + best / 2) % N;
    endtask

    task automatic sweep(input logic [N-1:0] m, input int l, input bit poke, input string tag);
        int ew, ep, ef, guard;
        mask = m; lat = l; hs_count = 0; monitor_on = 1;
        expect_result(m, ew, ep, ef);
        @(negedge clk); sweep_start = 1;
        @(negedge clk); sweep_start = 0;
        check({tag, " R2 busy"}, int'(busy), 1);
        check({tag, " R2 req"}, int'(step_req), 1);
        check({tag, " R2 phase0"}, int'(phase_sel), 0);
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (poke && hs_count == N / 2) sweep_start = 1;
            else sweep_start = 0;
        end
        sweep_start = 0;
        check({tag, " R10 done seen"}, int'(done), 1);
        check({tag, " R5 handshakes"}, hs_count, 2 * N);
        check({tag, " R6 width"}, int'(win_width), ew);
        check({tag, " R7 phase"}, int'(best_phase), ep);
        check({tag, " R9 fail flag"}, int'(no_window), ef);
        @(negedge clk);
        check({tag, " R10 done one cycle"}, int'(done), 0);
        repeat (3) @(negedge clk);
        check({tag, " R10 held width"}, int'(win_width), ew);
        check({tag, " R10 held phase"}, int'(best_phase), ep);
        check({tag, " R10 idle"}, int'(busy), 0);
        monitor_on = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req", int'(step_req), 0);
        check("R1 done", int'(done), 0);
        check("R1 fail", int'(no_window), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 phase", int'(phase_sel), 0);
        check("R1 best", int'(best_phase), 0);
        check("R1 width", int'(win_width), 0);
        rst_n = 1;
        @(negedge clk);
        sweep(16'h03F0, 0, 0, "plain");        // R6 R7: width 6, phase 7
        sweep(16'hE007, 2, 0, "wrap R8");      // width 6, phase 0
        sweep(16'h0000, 1, 0, "none R9");      // fail
        sweep(16'hFFFF, 0, 0, "all");          // width 16, phase 8
        sweep(16'h0E1C, 3, 0, "tie");          // width 3, phase 3
        sweep(16'h8000, 1, 0, "single");       // width 1, phase 15
        sweep(16'h07C6, 0, 1, "poke R10");     // width 5, phase 8, start ignored
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule